// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a wide synchronous up-counter built from identical narrow slices. Every slice has two count enables. The first is a broadcast enable that every slice shares. The second is a chain enable, and it also gates that slice's carry output. A slice's carry goes high when all of its bits are 1 and its chain enable is high. That carry drives the chain enable of the next more significant slice. As a result, an upper slice steps only in a cycle where every bit below it is 1. All bits of the wide count change on the same clock edge.

The least significant slice takes its chain enable from a top-level input. That input is normally tied to the broadcast enable. Each slice also has a synchronous clear and a synchronous parallel load, both active low. The top module chains a parameterised number of slices. It presents a single wide count, a single wide load value and the carry of the most significant slice, so several such counters can in turn be cascaded.

Top module: `casc_counter`

## Requirements
- R1: On a rising clock edge with clr_n and load_n high and both cnt_en and chain_en high, count increases by exactly 1.
- R2: With clr_n low at a rising edge, count becomes 0 on that edge, whatever load_n, cnt_en and chain_en are.
- R3: With clr_n high and load_n low at a rising edge, count takes the value of load_val on that edge, even when both enables are high.
- R4: With clr_n and load_n high, count keeps its value across an edge if cnt_en or chain_en is low.
- R5: carry_out is combinational and equals 1 exactly when every bit of count is 1 and chain_en is 1, independent of cnt_en.
- R6: A more significant slice advances only on an edge where every less significant bit of count is 1 and both enables are high. The chained slices together count as one plain binary counter of SLICES*SLICE_W bits.
- R7: Counting from the all-ones value wraps count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all slices |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Broadcast count enable to every slice |
| chain_en | input | 1 | Chain enable of the least significant slice; also gates carry_out |
| load_val | input | SLICES*SLICE_W | Parallel value copied into count on load |
| count | output | SLICES*SLICE_W | Current wide count |
| carry_out | output | 1 | High when count is all ones and chain_en is high |

## Verification
The bench drives the nibble boundaries 0x00FF to 0x0100 and 0x0FFF to 0x1000. A chain that let an upper slice step on its own enable, or that ignored a lower carry, would give a wrong upper nibble at these points. It holds the count at all ones while it toggles each enable separately. A carry gated by the wrong enable, or not gated at all, shows up there. It also applies clear with load asserted, and load with counting enabled. A wrong priority order would leave the loaded or incremented value in place of 0 or load_val. A long run of random enables, loads and clears is compared against an integer reference, which catches wrap and cascade errors at any boundary.

// File: rtl/casc_pkg.sv
package casc_pkg;

  // Operation a slice performs on the next edge, in priority order.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;

  // Clear beats load, load beats count (R2, R3).
  function automatic op_e pick_op(logic clr_n, logic load_n, logic step_ok);
    if (!clr_n)       return OP_CLEAR;
    else if (!load_n) return OP_LOAD;
    else if (step_ok) return OP_COUNT;
    else              return OP_HOLD;
  endfunction

endpackage

// File: rtl/casc_op_dec.sv
module casc_op_dec
  import casc_pkg::*;
(
  input  logic clr_n,
  input  logic load_n,
  input  logic en_bcast,
  input  logic en_chain,
  output logic step_ok,
  output op_e  op
);

  // Stepping needs both enables at once (R1).
  assign step_ok = en_bcast & en_chain;
  assign op      = pick_op(clr_n, load_n, step_ok);

endmodule

// File: rtl/casc_slice.sv
module casc_slice
  import casc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_bcast,
  input  logic         en_chain,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);

  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ZERO     = '0;

  logic step_ok;
  op_e  op;
  logic full_w;

  casc_op_dec u_dec (
    .clr_n   (clr_n),
    .load_n  (load_n),
    .en_bcast(en_bcast),
    .en_chain(en_chain),
    .step_ok (step_ok),
    .op      (op)
  );

  function automatic logic [W-1:0] next_val(op_e o, logic [W-1:0] cur, logic [W-1:0] ld);
    unique case (o)
      OP_CLEAR: return ZERO;
      OP_LOAD:  return ld;
      OP_COUNT: return cur + 1'b1;
      default:  return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    q <= next_val(op, q, din);
  end

  // Carry is gated by the chain enable only (R5).
  assign full_w = (q == ALL_ONES);
  assign carry  = full_w & en_chain;

  p_clear_r2: assert property (@(posedge clk)
    !clr_n |=> (q == ZERO));

  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && !load_n) |=> (q == $past(din)));

  p_step_r1: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(clr_n) && clr_n && load_n && en_bcast && en_chain) |=> (q == $past(q) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(clr_n) && clr_n && load_n && !(en_bcast && en_chain)) |=> $stable(q));

endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int SLICES  = 4,
  parameter int SLICE_W = 4
) (
  input  logic                      clk,
  input  logic                      clr_n,
  input  logic                      load_n,
  input  logic                      cnt_en,
  input  logic                      chain_en,
  input  logic [SLICES*SLICE_W-1:0] load_val,
  output logic [SLICES*SLICE_W-1:0] count,
  output logic                      carry_out
);

  localparam int WIDTH = SLICES * SLICE_W;
  localparam logic [WIDTH-1:0] WIDE_ONES = '1;
  localparam logic [WIDTH-1:0] WIDE_ZERO = '0;

  // chain[k] is the chain enable into slice k; chain[SLICES] leaves the block.
  logic [SLICES:0] chain;
  assign chain[0] = chain_en;

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    casc_slice #(.W(SLICE_W)) u_slice (
      .clk     (clk),
      .clr_n   (clr_n),
      .load_n  (load_n),
      .en_bcast(cnt_en),
      .en_chain(chain[g]),
      .din     (load_val[g*SLICE_W +: SLICE_W]),
      .q       (count[g*SLICE_W +: SLICE_W]),
      .carry   (chain[g+1])
    );
  end

  assign carry_out = chain[SLICES];

  p_carry_full_r5: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> ((count == WIDE_ONES) && chain_en));

  p_wide_step_r6: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(clr_n) && clr_n && load_n && cnt_en && chain_en) |=> (count == $past(count) + 1'b1));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(clr_n) && clr_n && load_n && cnt_en && chain_en && (count == WIDE_ONES)) |=> (count == WIDE_ZERO));

endmodule

// File: tb/casc_counter_tb.sv
`timescale 1ns/1ps
module casc_counter_tb;

  localparam int SL = 4;
  localparam int SW = 4;
  localparam int N  = SL * SW;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         load_n = 1'b1;
  logic         cnt_en = 1'b0;
  logic         chain_en = 1'b0;
  logic [N-1:0] load_val = '0;
  logic [N-1:0] count;
  logic         carry_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  casc_counter #(.SLICES(SL), .SLICE_W(SW)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .load_val(load_val), .count(count), .carry_out(carry_out)
  );

  typedef struct packed {
    logic        clr_n;
    logic        load_n;
    logic        en_b;
    logic        en_c;
    logic [15:0] din;
    logic [15:0] exp_q;
    logic        exp_c;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 16'h5555, 16'h0000, 1'b0, 4'd2}, // R2 clear beats count
    '{1'b0, 1'b0, 1'b1, 1'b1, 16'h1234, 16'h0000, 1'b0, 4'd2}, // R2 clear beats load
    '{1'b1, 1'b0, 1'b1, 1'b1, 16'h00FE, 16'h00FE, 1'b0, 4'd3}, // R3 load beats count
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'hA5A5, 16'h00FF, 1'b0, 4'd1}, // R1 step
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'hA5A5, 16'h0100, 1'b0, 4'd6}, // R6 carry into slice 2
    '{1'b1, 1'b1, 1'b0, 1'b1, 16'hA5A5, 16'h0100, 1'b0, 4'd4}, // R4 broadcast low
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'hA5A5, 16'h0100, 1'b0, 4'd4}, // R4 chain low
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFE, 16'hFFFE, 1'b0, 4'd3}, // R3 load, idle enables
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'hA5A5, 16'hFFFF, 1'b1, 4'd5}, // R5 full with chain high
    '{1'b1, 1'b1, 1'b0, 1'b1, 16'hA5A5, 16'hFFFF, 1'b1, 4'd5}, // R5 carry ignores broadcast
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'hA5A5, 16'hFFFF, 1'b0, 4'd5}, // R5 carry gated by chain
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'hA5A5, 16'h0000, 1'b0, 4'd7}, // R7 wrap
    '{1'b1, 1'b0, 1'b1, 1'b1, 16'h0FFF, 16'h0FFF, 1'b0, 4'd3}, // R3 load
    '{1'b1, 1'b1, 1'b0, 1'b1, 16'hA5A5, 16'h0FFF, 1'b0, 4'd6}, // R6 full lows, broadcast low
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'hA5A5, 16'h1000, 1'b0, 4'd6}, // R6 carry into top slice
    '{1'b0, 1'b1, 1'b1, 1'b1, 16'hA5A5, 16'h0000, 1'b0, 4'd2}  // R2 clear from nonzero
  };

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic b, input logic t, input logic [N-1:0] d);
    clr_n = c; load_n = l; cnt_en = b; chain_en = t; load_val = d;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [N-1:0] ref_next(logic [N-1:0] cur, logic c, logic l, logic b, logic t, logic [N-1:0] d);
    if (c == 1'b0) return '0;
    if (l == 1'b0) return d;
    if (b && t)    return cur + 16'd1;
    return cur;
  endfunction

  initial begin
    repeat (160000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] model;
    // Reset state: clear held low for several edges (R2).
    repeat (3) drive(1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF);
    check(count == 16'h0000, "R2 reset count", count, 16'h0000);
    check(carry_out == 1'b0, "R5 reset carry", {15'd0, carry_out}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].clr_n, VECS[i].load_n, VECS[i].en_b, VECS[i].en_c, VECS[i].din);
      check(count == VECS[i].exp_q, $sformatf("R%0d vec %0d count", VECS[i].req, i), count, VECS[i].exp_q);
      check(carry_out == VECS[i].exp_c, $sformatf("R%0d vec %0d carry", VECS[i].req, i),
            {15'd0, carry_out}, {15'd0, VECS[i].exp_c});
    end

    // Full-range R6 and R7 sweep: count through every value and wrap.
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0);
    model = '0;
    for (int k = 0; k < 65537; k++) begin
      drive(1'b1, 1'b1, 1'b1, 1'b1, 16'h3C3C);
      model = model + 16'd1;
      if (count != model || k == 65536)
        check(count == model, "R6 R7 sweep", count, model);
    end

    // Random enables, loads and clears against an integer reference (R1 R4 R5 R6).
    model = count;
    for (int k = 0; k < 20000; k++) begin
      logic c, l, b, t;
      logic [N-1:0] d;
      c = ($urandom_range(0, 99) != 0);
      l = ($urandom_range(0, 49) != 0);
      b = $urandom_range(0, 3) != 0;
      t = $urandom_range(0, 3) != 0;
      d = ($urandom_range(0, 3) == 0) ? 16'hFFF0 + 16'($urandom_range(0, 15)) : 16'($urandom);
      drive(c, l, b, t, d);
      model = ref_next(model, c, l, b, t, d);
      if (count != model) check(1'b0, "R1 R4 R6 random count", count, model);
      if (carry_out != ((model == 16'hFFFF) && t))
        check(1'b0, "R5 random carry", {15'd0, carry_out}, {15'd0, (model == 16'hFFFF) && t});
    end
    check(count == model, "R6 random final", count, model);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule